// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source half of a two-stage interrupt controller. It owns a parameterised set of interrupt inputs whose global numbers start at a base value. Each input is fixed at build time as either an edge-event (message) source or a level source. Each carries a destination server, an 8-bit priority and an 8-bit saved priority. A priority of 0xFF masks the source. The block tracks per-source flags for asserted, sent, rejected and masked-pending. It turns input activity and configuration into presentation requests, each carrying a server, a global number and a priority, toward the presenter stage.

The presenter stage answers with reject and end-of-interrupt indications, each naming a global number, and with a request to resend everything. A resend walks the sources one per cycle in ascending order while `busy` is high. Reject and end-of-interrupt indications that arrive during the walk are dropped, so the sender must wait for `busy` to fall. Requests leave through one valid/ready port. When several sources are waiting, the lowest index is offered first. Configuration enters through a one-cycle write strobe, and a combinational read port returns any source's server, priority and saved priority.

Top module: `src_state_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF, saved priority 0xFF and server 0, all flags are clear, `presValid` is low and `busy` is low.
- R2: A message source that sees a one-cycle event on `irqIn[i]` while unmasked raises a request with number OFFSET+i, its server and its priority. The request is visible the cycle after the event.
- R3: A message event while masked sets masked-pending and raises no request. A later configuration write with a priority other than 0xFF clears masked-pending and raises the request. A write that keeps 0xFF leaves it pending.
- R4: A level source copies `irqIn[i]` into asserted. On every change it checks the source: if unmasked, asserted and not sent, it sets sent and raises a request. While sent stays set, no further request is raised.
- R5: A reject naming a message source sets its rejected flag and raises nothing. A reject naming a level source clears sent.
- R6: An end-of-interrupt naming a level source clears sent without a check. One naming a message source changes nothing.
- R7: A `resendReq` pulse while idle holds `busy` high for exactly NUM_SRC cycles and visits source k in the k-th of those cycles. A level source gets the check. A message source with rejected set has rejected cleared and is re-requested if unmasked.
- R8: While `busy` is high, reject, end-of-interrupt and `resendReq` inputs are ignored.
- R9: A configuration write stores server, priority and saved priority, and then runs the check on a level source.
- R10: With several requests waiting, the output offers the lowest index. A request stays offered until `presReady` is high in a cycle where it is offered.
- R11: Reject and end-of-interrupt numbers outside OFFSET..OFFSET+NUM_SRC-1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Per-source input: a one-cycle event pulse for message sources, a level for level sources |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | IDX_W | Local index of the source written |
| cfgServer | input | SRV_W | Server to store |
| cfgPrio | input | 8 | Priority to store (0xFF masks) |
| cfgSaved | input | 8 | Saved priority to store |
| rdIdx | input | IDX_W | Local index read back |
| rdServer | output | SRV_W | Server of source rdIdx |
| rdPrio | output | 8 | Priority of source rdIdx |
| rdSaved | output | 8 | Saved priority of source rdIdx |
| rejValid | input | 1 | Reject indication |
| rejNum | input | NUM_W | Global number rejected |
| eoiValid | input | 1 | End-of-interrupt indication |
| eoiNum | input | NUM_W | Global number completed |
| resendReq | input | 1 | Request to resend every source |
| busy | output | 1 | Resend walk in progress |
| presValid | output | 1 | Presentation request valid |
| presReady | input | 1 | Presenter accepts the request |
| presServer | output | SRV_W | Server of the request |
| presNum | output | NUM_W | Global number of the request |
| presPrio | output | 8 | Priority of the request |

## Verification
Every stimulus is sampled at one clock edge, and the request it causes is offered from that edge on, one cycle later. A grant with `presReady` removes the request at the same edge. The read-back port reflects a configuration write one cycle later. `busy` rises one cycle after `resendReq`, and source k is visited k cycles after that. A behavioural model in the bench applies the same inputs at each rising edge. The design's outputs are compared with it at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic visit;
    logic rejEn;
    logic eoiEn;
  } ctlStrobe_t;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resendReq,
  input  logic             rejValid,
  input  logic             eoiValid,
  output logic             busy,
  output logic [IDX_W-1:0] visitIdx,
  output ctlStrobe_t       strobe
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic [IDX_W-1:0] scanCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      scanCnt <= '0;
    end else if (!busy) begin
      if (resendReq) begin
        busy    <= 1'b1;
        scanCnt <= '0;
      end
    end else if (scanCnt == LAST) begin
      busy <= 1'b0;
    end else begin
      scanCnt <= scanCnt + 1'b1;
    end
  end

  assign visitIdx     = scanCnt;
  assign strobe.visit = busy;
  assign strobe.rejEn = rejValid & ~busy;
  assign strobe.eoiEn = eoiValid & ~busy;
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter int OFFSET = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = '0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   visitIdx,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [PRIO_W-1:0]  cfgSaved,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [SRV_W-1:0]   rdServer,
  output logic [PRIO_W-1:0]  rdPrio,
  output logic [PRIO_W-1:0]  rdSaved,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic [NUM_W-1:0]   eoiNum,
  output logic               presValid,
  input  logic               presReady,
  output logic [SRV_W-1:0]   presServer,
  output logic [NUM_W-1:0]   presNum,
  output logic [PRIO_W-1:0]  presPrio
);
  logic [NUM_SRC-1:0] reqVec;
  logic [NUM_SRC-1:0] grantVec;
  logic [SRV_W-1:0]   srvArr [NUM_SRC];
  logic [PRIO_W-1:0]  prioArr[NUM_SRC];
  logic [PRIO_W-1:0]  savArr [NUM_SRC];
  logic [IDX_W-1:0]   selIdx;

  // lowest index wins
  always_comb begin
    selIdx    = '0;
    presValid = 1'b0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (reqVec[k]) begin
        selIdx    = IDX_W'(k);
        presValid = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [NUM_W-1:0] MY_NUM = NUM_W'(OFFSET + i);
    localparam bit IS_LVL = LEVEL_MAP[i];

    logic [SRV_W-1:0]  srvQ;
    logic [PRIO_W-1:0] prioQ, savQ, prioN;
    logic assQ, sentQ, rejQ, mpQ, reqQ;
    logic sentN, rejN, mpN, fire;
    logic cfgHit, rejHit, eoiHit, visitHit, maskN, chk;

    assign grantVec[i] = presReady & presValid & (selIdx == IDX_W'(i));
    assign cfgHit   = cfgWe & (cfgIdx == IDX_W'(i));
    assign rejHit   = strobe.rejEn & (rejNum == MY_NUM);
    assign eoiHit   = strobe.eoiEn & (eoiNum == MY_NUM);
    assign visitHit = strobe.visit & (visitIdx == IDX_W'(i));
    assign prioN    = cfgHit ? cfgPrio : prioQ;
    assign maskN    = (prioN == PRIO_OFF);

    always_comb begin
      sentN = sentQ;
      rejN  = rejQ;
      mpN   = mpQ;
      fire  = 1'b0;
      chk   = 1'b0;
      if (IS_LVL) begin
        sentN = sentQ & ~rejHit & ~eoiHit;
        chk   = cfgHit | visitHit | (irqIn[i] != assQ);
        if (chk && !maskN && irqIn[i] && !sentN) begin
          sentN = 1'b1;
          fire  = 1'b1;
        end
      end else begin
        if (cfgHit && mpQ && !maskN) begin
          mpN  = 1'b0;
          fire = 1'b1;
        end
        if (rejHit) rejN = 1'b1;
        if (visitHit && rejQ) begin
          rejN = 1'b0;
          if (!maskN) fire = 1'b1;
        end
        if (irqIn[i]) begin
          if (maskN) mpN = 1'b1;
          else       fire = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srvQ  <= '0;
        prioQ <= PRIO_OFF;
        savQ  <= PRIO_OFF;
        assQ  <= 1'b0;
        sentQ <= 1'b0;
        rejQ  <= 1'b0;
        mpQ   <= 1'b0;
        reqQ  <= 1'b0;
      end else begin
        if (cfgHit) begin
          srvQ <= cfgServer;
          savQ <= cfgSaved;
        end
        prioQ <= prioN;
        assQ  <= IS_LVL ? irqIn[i] : 1'b0;
        sentQ <= sentN;
        rejQ  <= rejN;
        mpQ   <= mpN;
        reqQ  <= (reqQ & ~grantVec[i]) | fire;
      end
    end

    assign reqVec[i]  = reqQ;
    assign srvArr[i]  = srvQ;
    assign prioArr[i] = prioQ;
    assign savArr[i]  = savQ;
  end

  assign presServer = srvArr[selIdx];
  assign presPrio   = prioArr[selIdx];
  assign presNum    = NUM_W'(OFFSET) + NUM_W'(selIdx);
  assign rdServer   = srvArr[rdIdx];
  assign rdPrio     = prioArr[rdIdx];
  assign rdSaved    = savArr[rdIdx];
endmodule

// File: rtl/src_state_ctrl.sv
module src_state_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter int OFFSET = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [7:0]         cfgPrio,
  input  logic [7:0]         cfgSaved,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [SRV_W-1:0]   rdServer,
  output logic [7:0]         rdPrio,
  output logic [7:0]         rdSaved,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendReq,
  output logic               busy,
  output logic               presValid,
  input  logic               presReady,
  output logic [SRV_W-1:0]   presServer,
  output logic [NUM_W-1:0]   presNum,
  output logic [7:0]         presPrio
);
  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] visitIdx;

  isc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .resendReq(resendReq),
    .rejValid(rejValid), .eoiValid(eoiValid),
    .busy(busy), .visitIdx(visitIdx), .strobe(strobe)
  );

  isc_datapath #(
    .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W),
    .OFFSET(OFFSET), .LEVEL_MAP(LEVEL_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .visitIdx(visitIdx),
    .irqIn(irqIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio), .cfgSaved(cfgSaved),
    .rdIdx(rdIdx), .rdServer(rdServer), .rdPrio(rdPrio), .rdSaved(rdSaved),
    .rejNum(rejNum), .eoiNum(eoiNum),
    .presValid(presValid), .presReady(presReady),
    .presServer(presServer), .presNum(presNum), .presPrio(presPrio)
  );
endmodule

// File: rtl/src_state_ctrl_chk.sv
module src_state_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_W = 12,
  parameter int OFFSET = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             resendReq,
  input logic             presValid,
  input logic             presReady,
  input logic [NUM_W-1:0] presNum
);
  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R1: nothing offered and no walk in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!presValid && !busy));

  // R10: a request is only withdrawn by a grant
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (presValid && !presReady) |=> presValid);

  // R2: offered numbers lie in the block's own range
  a_r2_num_in_range: assert property (@(posedge clk) disable iff (!rstN)
    presValid |-> (presNum >= NUM_W'(OFFSET) && presNum < NUM_W'(OFFSET + NUM_SRC)));

  // R7: the walk lasts no more than one cycle per source
  a_r7_walk_length: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= NUM_SRC);

  // R7: the walk starts only on request
  a_r7_walk_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(resendReq));
endmodule

bind src_state_ctrl src_state_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .OFFSET(OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .resendReq(resendReq),
  .presValid(presValid), .presReady(presReady), .presNum(presNum)
);

// File: tb/src_state_ctrl_test.sv
module src_state_ctrl_test;
  localparam int N = 8;
  localparam int SW = 4;
  localparam int NW = 12;
  localparam int OFS = 16;
  localparam logic [N-1:0] LVL = 8'hF0;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic cfgWe = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [SW-1:0] cfgServer = '0;
  logic [7:0] cfgPrio = '0, cfgSaved = '0;
  logic [IW-1:0] rdIdx = '0;
  logic [SW-1:0] rdServer;
  logic [7:0] rdPrio, rdSaved;
  logic rejValid = 1'b0, eoiValid = 1'b0, resendReq = 1'b0, presReady = 1'b0;
  logic [NW-1:0] rejNum = '0, eoiNum = '0;
  logic busy, presValid;
  logic [SW-1:0] presServer;
  logic [NW-1:0] presNum;
  logic [7:0] presPrio;

  always #4 clk = ~clk;

  src_state_ctrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio), .cfgSaved(cfgSaved),
    .rdIdx(rdIdx), .rdServer(rdServer), .rdPrio(rdPrio), .rdSaved(rdSaved),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .busy(busy), .presValid(presValid),
    .presReady(presReady), .presServer(presServer), .presNum(presNum),
    .presPrio(presPrio)
  );

  int vecs = 0, bad = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference
  int mPrio[N], mSav[N], mSrv[N];
  bit mAss[N], mSent[N], mRej[N], mMp[N], mReq[N];
  bit mBusy;
  int mCnt;

  function automatic int firstReq();
    for (int k = 0; k < N; k++) if (mReq[k]) return k;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < N; k++) begin
        mPrio[k] = 255; mSav[k] = 255; mSrv[k] = 0;
        mAss[k] = 0; mSent[k] = 0; mRej[k] = 0; mMp[k] = 0; mReq[k] = 0;
      end
      mBusy = 0; mCnt = 0;
    end else begin
      int sel, scan;
      bit gr, rejOk, eoiOk;
      sel = firstReq();
      gr = presReady && sel >= 0;
      scan = mBusy ? mCnt : -1;
      rejOk = rejValid && !mBusy;
      eoiOk = eoiValid && !mBusy;
      for (int k = 0; k < N; k++) begin
        bit cfg, masked, fire, rh, eh;
        cfg = cfgWe && (int'(cfgIdx) == k);
        rh = rejOk && (int'(rejNum) == OFS + k);
        eh = eoiOk && (int'(eoiNum) == OFS + k);
        fire = 0;
        if (cfg) begin
          mSrv[k] = int'(cfgServer); mPrio[k] = int'(cfgPrio); mSav[k] = int'(cfgSaved);
        end
        masked = (mPrio[k] == 255);
        if (LVL[k]) begin
          bit chk;
          if (rh || eh) mSent[k] = 0;
          chk = cfg || scan == k || (irqIn[k] != mAss[k]);
          mAss[k] = irqIn[k];
          if (chk && !masked && mAss[k] && !mSent[k]) begin
            mSent[k] = 1; fire = 1;
          end
        end else begin
          if (cfg && mMp[k] && !masked) begin mMp[k] = 0; fire = 1; end
          if (rh) mRej[k] = 1;
          if (scan == k && mRej[k]) begin
            mRej[k] = 0;
            if (!masked) fire = 1;
          end
          if (irqIn[k]) begin
            if (masked) mMp[k] = 1; else fire = 1;
          end
        end
        if (gr && sel == k) mReq[k] = 0;
        if (fire) mReq[k] = 1;
      end
      if (!mBusy) begin
        if (resendReq) begin mBusy = 1; mCnt = 0; end
      end else if (mCnt == N - 1) mBusy = 0;
      else mCnt++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      int sel;
      sel = firstReq();
      check(phase, "presValid", int'(presValid), int'(sel >= 0));
      if (sel >= 0) begin
        check(phase, "presNum", int'(presNum), OFS + sel);
        check(phase, "presServer", int'(presServer), mSrv[sel]);
        check(phase, "presPrio", int'(presPrio), mPrio[sel]);
      end
      check(phase, "busy", int'(busy), int'(mBusy));
      check(phase, "rdPrio", int'(rdPrio), mPrio[int'(rdIdx)]);
      check(phase, "rdSaved", int'(rdSaved), mSav[int'(rdIdx)]);
      check(phase, "rdServer", int'(rdServer), mSrv[int'(rdIdx)]);
    end
  end

  task automatic done();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done();
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clearIn();
    cfgWe = 0; rejValid = 0; eoiValid = 0; resendReq = 0;
    for (int k = 0; k < N; k++) if (!LVL[k]) irqIn[k] = 1'b0;
  endtask

  task automatic cfg(int idx, int srv, int pr, int sv);
    cfgWe = 1; cfgIdx = IW'(idx); cfgServer = SW'(srv);
    cfgPrio = 8'(pr); cfgSaved = 8'(sv);
    tick(); clearIn();
  endtask

  task automatic pulse(int idx);
    irqIn[idx] = 1'b1; tick(); clearIn();
  endtask

  task automatic rej(int num);
    rejValid = 1; rejNum = NW'(num); tick(); clearIn();
  endtask

  task automatic eoi(int num);
    eoiValid = 1; eoiNum = NW'(num); tick(); clearIn();
  endtask

  task automatic drain();
    presReady = 1; tick(10); presReady = 0;
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick();
    // R1: reset values through the read port
    phase = "R1";
    for (int k = 0; k < N; k++) begin rdIdx = IW'(k); tick(); end
    check("R1", "presValid after reset", int'(presValid), 0);
    pulse(0);               // masked event: no request
    tick(2);
    check("R1", "masked event offers nothing", int'(presValid), 0);

    phase = "R3";
    cfg(0, 3, 255, 9);      // still masked: stays pending
    tick(2);
    check("R3", "pending held while masked", int'(presValid), 0);
    cfg(0, 3, 5, 9);        // unmask releases the pending event
    check("R3", "release presented", int'(presNum), OFS + 0);
    drain();

    phase = "R2";
    cfg(1, 6, 2, 7);
    pulse(1);
    check("R2", "message number", int'(presNum), OFS + 1);
    check("R2", "message server", int'(presServer), 6);
    drain();

    phase = "R10";
    cfg(2, 1, 4, 4);
    cfg(3, 2, 3, 3);
    irqIn[2] = 1; irqIn[3] = 1; tick(); clearIn();
    tick(3);
    check("R10", "lowest index first", int'(presNum), OFS + 2);
    presReady = 1; tick(); presReady = 0;
    check("R10", "next index after grant", int'(presNum), OFS + 3);
    drain();

    phase = "R4";
    cfg(4, 5, 1, 1);
    irqIn[4] = 1; tick();
    check("R4", "level presented", int'(presNum), OFS + 4);
    drain();
    tick(3);
    check("R4", "no repeat while sent", int'(presValid), 0);

    phase = "R6";
    eoi(OFS + 1);           // message EOI: no change
    eoi(OFS + 4);           // clears sent, no check
    tick(2);
    check("R6", "eoi alone re-presents nothing", int'(presValid), 0);
    irqIn[4] = 0; tick(); irqIn[4] = 1; tick();
    check("R6", "re-presented after change", int'(presValid), 1);
    drain();

    phase = "R5";
    rej(OFS + 4);
    rej(OFS + 1);
    tick(2);
    check("R5", "reject raises nothing", int'(presValid), 0);

    phase = "R11";
    rej(OFS + N); rej(OFS - 1); eoi(OFS + N + 3);
    tick(2);

    phase = "R7";
    resendReq = 1; tick(); clearIn();
    check("R7", "busy raised", int'(busy), 1);
    tick(N + 2);
    check("R7", "walk finished", int'(busy), 0);
    drain();

    phase = "R8";
    resendReq = 1; tick(); clearIn();
    rejValid = 1; rejNum = NW'(OFS + 4); resendReq = 1;
    eoiValid = 1; eoiNum = NW'(OFS + 4);
    tick(); clearIn();
    tick(N + 2);
    drain();
    resendReq = 1; tick(); clearIn();
    tick(N + 2);
    check("R8", "dropped reject left sent set", int'(presValid), 0);

    phase = "R9";
    irqIn[5] = 1; tick(2);
    check("R9", "masked level silent", int'(presValid), 0);
    cfg(5, 7, 6, 2);
    check("R9", "config check presents", int'(presNum), OFS + 5);
    rdIdx = 3'd5; tick();
    check("R9", "saved priority stored", int'(rdSaved), 2);
    drain();
    irqIn = '0; tick(3);

    done();
  end
endmodule